// File: doc/BRIEF.md
# Recursive Split Unsigned Multiplier

This block multiplies two 8-bit unsigned operands and returns their 16-bit product. It has no clock or state: the result depends only on the present operands. Inside, each operand is cut in half again and again. At the bottom is a small 2×2 cell that forms its result from straight-down and diagonal bit products. Four such cells make a 4×4 multiplier, and four 4×4 multipliers make the 8×8 result.

At each level a combiner module adds the four sub-products. First it adds the two cross terms. Then it places that sum one half-width above the low product and adds it to the high product placed one full width up. One-bit products are plain AND gates. Every sum is formed by a chain of full adders. The 2×2 cell, the 4×4 multiplier and the combiner are separate modules, so each level can be checked by itself.

Top module: `vc_mul8x8`

## Requirements
- R1: In the 2×2 cell (operands x[1:0], y[1:0], output q[3:0]), q[0] equals x[0] AND y[0].
- R2: In the 2×2 cell, q[1] is the XOR of the cross products x[1]·y[0] and x[0]·y[1]; their AND is a carry into bit 2.
- R3: In the 2×2 cell, q[2] is x[1]·y[1] XOR the bit-1 carry, and q[3] is their AND. For all 16 operand pairs, q equals the 2-bit unsigned product.
- R4: The 4×4 multiplier splits each operand into 2-bit halves and feeds four 2×2 cells. Its 8-bit output equals the exact unsigned product for all 256 operand pairs.
- R5: The 8×8 product equals hh·256 + (hl + lh)·16 + ll. Here hh, hl, lh and ll are the four 4-bit-by-4-bit sub-products of the operand halves: high·high, high·low, low·high and low·low.
- R6: prod_o equals a_i × b_i exactly for every one of the 65,536 operand pairs.
- R7: A zero operand gives a zero product. An operand of 1 passes the other operand through unchanged.
- R8: No carry is lost at any level. 255 × 255 gives 16'hFE01, and the cross-term sum keeps its extra carry bit.
- R9: prod_o[0] equals a_i[0] AND b_i[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First unsigned operand |
| b_i | input | 8 | Second unsigned operand |
| prod_o | output | 16 | Unsigned product a_i × b_i |

## Verification
The largest operands are the case most likely to expose a dropped carry. With both at 255, the cross-term sum needs its ninth bit, and a design that truncated it would return a product short by a multiple of 16 or 256. Operands that load only one half put the full weight on a single sub-product. A swapped hl/lh weighting or a wrong shift there shows up as a misplaced nibble. The 2×2 and 4×4 levels are swept on their own, so a bad carry from q[1] into q[2] is tied to the cell. The full 8×8 sweep then confirms that no pair escapes.

// File: rtl/vc_mul_pkg.sv
package vc_mul_pkg;
  localparam int unsigned LEAF_W = 2;
  localparam int unsigned MID_W  = 4;
  localparam int unsigned TOP_W  = 8;
  typedef logic [2*TOP_W-1:0] prod_t;
endpackage

// File: rtl/vc_fa.sv
module vc_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ c_i;
  assign c_o = (x_i & y_i) | (c_i & (x_i ^ y_i));
endmodule

// File: rtl/vc_rca.sv
// Ripple adder without carry out; widen operands by one bit to keep it.
module vc_rca #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] s_o
);
  logic [W-1:0] cy;
  assign cy[0] = c_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_fa
      vc_fa u_fa (.x_i(x_i[i]), .y_i(y_i[i]), .c_i(cy[i]), .s_o(s_o[i]), .c_o(cy[i+1]));
    end else begin : g_last
      assign s_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
    end
  end
endmodule

// File: rtl/vc_cell2.sv
module vc_cell2 (
  input  logic [1:0] x_i,
  input  logic [1:0] y_i,
  output logic [3:0] q_o
);
  logic p00, p01, p10, p11, c1;
  assign p00 = x_i[0] & y_i[0];
  assign p10 = x_i[1] & y_i[0];
  assign p01 = x_i[0] & y_i[1];
  assign p11 = x_i[1] & y_i[1];
  assign c1  = p10 & p01;
  assign q_o = {p11 & c1, p11 ^ c1, p10 ^ p01, p00};
endmodule

// File: rtl/vc_combine.sv
// Merges four HxH sub-products into one 2H x 2H product.
module vc_combine #(
  parameter int unsigned H = 2
) (
  input  logic [2*H-1:0] hh_i,
  input  logic [2*H-1:0] hl_i,
  input  logic [2*H-1:0] lh_i,
  input  logic [2*H-1:0] ll_i,
  output logic [4*H-1:0] p_o
);
  localparam int unsigned MW = 2*H + 1;
  localparam int unsigned UW = 3*H;

  logic [MW-1:0] mid;
  logic [UW-1:0] upper;

  vc_rca #(.W(MW)) u_mid (
    .x_i({1'b0, hl_i}), .y_i({1'b0, lh_i}), .c_i(1'b0), .s_o(mid)
  );

  vc_rca #(.W(UW)) u_up (
    .x_i({hh_i, ll_i[2*H-1:H]}),
    .y_i({{(H-1){1'b0}}, mid}),
    .c_i(1'b0),
    .s_o(upper)
  );

  assign p_o = {upper, ll_i[H-1:0]};
endmodule

// File: rtl/vc_mul4.sv
module vc_mul4 (
  input  logic [3:0] x_i,
  input  logic [3:0] y_i,
  output logic [7:0] p_o
);
  localparam int unsigned H = vc_mul_pkg::LEAF_W;
  logic [2*H-1:0] sub [4];

  // index = {x half, y half}: 3 hh, 2 hl, 1 lh, 0 ll
  for (genvar k = 0; k < 4; k++) begin : g_cell
    vc_cell2 u_cell (
      .x_i(x_i[(k/2)*H +: H]),
      .y_i(y_i[(k%2)*H +: H]),
      .q_o(sub[k])
    );
  end

  vc_combine #(.H(H)) u_comb (
    .hh_i(sub[3]), .hl_i(sub[2]), .lh_i(sub[1]), .ll_i(sub[0]), .p_o(p_o)
  );
endmodule

// File: rtl/vc_mul8x8.sv
module vc_mul8x8 (
  input  logic [7:0]  a_i,
  input  logic [7:0]  b_i,
  output logic [15:0] prod_o
);
  localparam int unsigned H = vc_mul_pkg::MID_W;
  logic [2*H-1:0] sub [4];

  for (genvar k = 0; k < 4; k++) begin : g_quad
    vc_mul4 u_quad (
      .x_i(a_i[(k/2)*H +: H]),
      .y_i(b_i[(k%2)*H +: H]),
      .p_o(sub[k])
    );
  end

  vc_combine #(.H(H)) u_comb (
    .hh_i(sub[3]), .hl_i(sub[2]), .lh_i(sub[1]), .ll_i(sub[0]), .p_o(prod_o)
  );
endmodule

// File: rtl/vc_mul8x8_chk.sv
module vc_mul8x8_chk (
  input logic [7:0]  a_i,
  input logic [7:0]  b_i,
  input logic [15:0] prod_o
);
  logic [15:0] ref_p;
  logic [15:0] hh_ref;
  assign ref_p  = 16'(a_i) * 16'(b_i);
  assign hh_ref = 16'(a_i[7:4]) * 16'(b_i[7:4]);

  always_comb begin
    // R6
    exact_prod_chk: assert (prod_o == ref_p);
    // R7
    zero_op_chk: assert (!(a_i == 8'd0 || b_i == 8'd0) || prod_o == 16'd0);
    // R7
    unit_op_chk: assert (a_i != 8'd1 || prod_o == {8'd0, b_i});
    // R8
    no_overflow_chk: assert (prod_o <= 16'hFE01);
    // R9
    lsb_chk: assert (prod_o[0] == (a_i[0] & b_i[0]));
    // R5
    high_weight_chk: assert (prod_o >= (hh_ref << 8));
  end
endmodule

bind vc_mul8x8 vc_mul8x8_chk u_chk (.a_i(a_i), .b_i(b_i), .prod_o(prod_o));

// File: tb/tb_vc_mul8x8.sv
module tb_vc_mul8x8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  a, b;
  logic [15:0] p;
  logic [1:0]  cx, cy;
  logic [3:0]  cq;
  logic [3:0]  mx, my;
  logic [7:0]  mp;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  vc_mul8x8 dut (.a_i(a), .b_i(b), .prod_o(p));
  vc_cell2  u_c2 (.x_i(cx), .y_i(cy), .q_o(cq));
  vc_mul4   u_m4 (.x_i(mx), .y_i(my), .p_o(mp));

  function automatic logic [15:0] ref_mul(input logic [7:0] x, input logic [7:0] y);
    return 16'(x) * 16'(y);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply8(input logic [7:0] x, input logic [7:0] y, input string req);
    @(negedge clk);
    a = x; b = y;
    @(posedge clk); #1;
    chk(req, p, ref_mul(x, y));
  endtask

  initial begin
    a = 0; b = 0; cx = 0; cy = 0; mx = 0; my = 0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R7 idle", p, 16'd0);

    // R1 R2 R3: 2x2 cell exhaustive, bit by bit
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        cx = 2'(i); cy = 2'(j);
        #1;
        chk("R1", {15'd0, cq[0]}, {15'd0, cx[0] & cy[0]});
        chk("R2", {15'd0, cq[1]}, {15'd0, (cx[1] & cy[0]) ^ (cx[0] & cy[1])});
        chk("R3", {12'd0, cq}, 16'(i * j));
      end
    end

    // R4: 4x4 exhaustive
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        @(negedge clk);
        mx = 4'(i); my = 4'(j);
        #1;
        chk("R4", {8'd0, mp}, 16'(i * j));
      end
    end

    // R8 and R7 directed corners
    apply8(8'hFF, 8'hFF, "R8 max");
    chk("R8 const", p, 16'hFE01);
    apply8(8'h0F, 8'hF0, "R8 cross");
    apply8(8'hFF, 8'h0F, "R8 mid carry");
    apply8(8'h00, 8'hA5, "R7 zero");
    apply8(8'h01, 8'h5A, "R7 one");
    apply8(8'h80, 8'h80, "R5 hh only");
    apply8(8'hF0, 8'h0F, "R5 hl only");

    // R5: random half-weighted decomposition
    void'($urandom(32'd1234));
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] x, y;
      logic [15:0] e;
      x = 8'($urandom); y = 8'($urandom);
      e = (16'(x[7:4]) * 16'(y[7:4]) << 8)
        + ((16'(x[7:4]) * 16'(y[3:0]) + 16'(x[3:0]) * 16'(y[7:4])) << 4)
        + 16'(x[3:0]) * 16'(y[3:0]);
      @(negedge clk);
      a = x; b = y;
      @(posedge clk); #1;
      chk("R5", p, e);
      chk("R9", {15'd0, p[0]}, {15'd0, x[0] & y[0]});
    end

    // R6: exhaustive 8x8
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        @(negedge clk);
        a = 8'(i); b = 8'(j);
        #1;
        chk("R6", p, ref_mul(8'(i), 8'(j)));
      end
    end

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WATCHDOG);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule